// File: doc/BRIEF.md
# Timestamp Event Capture Unit

This block runs a 32-bit timestamp counter on its reference clock and records time-stamped events into a small queue that software drains over a simple word-addressed register port. An event can come from six kinds of source. Software can request a capture. The counter produces one when it wraps to zero and one when it crosses its midpoint. Four hardware pins produce one on each rising edge. Ethernet receive and transmit strobes produce one each, carrying a port number, a message type and a sequence ID.

Every event becomes a pair of words. One is the timestamp. The other is a descriptor that packs the port, the event kind, the message type and the sequence ID. Software reads the oldest pair and then writes the pop register to discard it. An interrupt line reports that work is pending. Software can also load a new value into the counter.

The event sources are strobes with no back-pressure, because a timestamp that is held back is no longer accurate. Each source has a one-entry holding slot. A fixed-priority arbiter moves one slot per cycle into the queue. When the queue is full, the event that reaches it is discarded and a sticky overflow flag is set. An event is also discarded when its source fires again while its slot is still occupied.

Top module: `tsu_event_capture`

## Requirements
- R1: While the run bit (control bit 0) is 1, the counter adds one every cycle. A write of 1 to bit 0 of the load-go register (word 4) puts the load-value register (word 3) into the counter on the next edge, whether or not the run bit is set.
- R2: When the counter steps from 0xFFFFFFFF to 0, a rollover event (kind 1) is queued with timestamp 0. When it steps from 0x7FFFFFFF to 0x80000000, a half-rollover event (kind 2) is queued with timestamp 0x80000000.
- R3: A write of 1 to bit 0 of the push register (word 2) queues a software event (kind 0). Its timestamp is the counter value in the cycle of the write.
- R4: A rising edge on hardware pin i (0..3) queues a pin event (kind 3) only if control bit 8+i is set. The port field of that event is i+1 and the timestamp is the counter value in the cycle the pin is first seen high.
- R5: A receive strobe queues kind 4 and a transmit strobe queues kind 5. Each copies its port, message type and sequence ID inputs into the descriptor.
- R6: Descriptor layout: port in bits 28:24, kind in bits 23:20, message type in bits 19:16, sequence ID in bits 15:0. All other bits are zero.
- R7: The queue holds 16 events. Word 9 shows the oldest timestamp and word 10 shows the oldest descriptor. A write of 1 to bit 0 of word 8 discards the oldest event. A pop on an empty queue has no effect.
- R8: An event that arrives while the queue is full is dropped and sets the sticky overflow flag (bit 1 of word 5). Writing 1 to that bit clears it.
- R9: Raw pending (bit 0 of word 5) is 1 when the queue is not empty or when the interrupt test bit (control bit 1) is set. Masked pending (bit 0 of word 6) and the irq pin both equal raw pending AND bit 0 of the interrupt enable register (word 7).
- R10: While the run bit is 0, the counter holds and no event of any kind is queued.
- R11: Events that fire in the same cycle enter the queue in this order: rollover, half-rollover, software, pins 1 to 4, receive, transmit.
- R12: Word 0 reads the constant 0x5A171902: module ID 0x5A17 in bits 31:16, RTL version 3 in bits 15:11, major version 1 in bits 10:8 and minor version 2 in bits 7:0. Control reads back 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from address) |
| hw_pin | input | 4 | Hardware push pins, rising-edge sensitive |
| rx_stb | input | 1 | Ethernet receive timestamp strobe |
| rx_port | input | 5 | Receive port number |
| rx_msg | input | 4 | Receive message type |
| rx_seq | input | 16 | Receive sequence ID |
| tx_stb | input | 1 | Ethernet transmit timestamp strobe |
| tx_port | input | 5 | Transmit port number |
| tx_msg | input | 4 | Transmit message type |
| tx_seq | input | 16 | Transmit sequence ID |
| irq | output | 1 | Masked pending interrupt |

## Verification
The bench loads the counter just below both wrap points. A design that compares against the wrong value, or stamps the pre-wrap count, would report a missing event or a timestamp that is off by one.

A software push and both Ethernet strobes are fired in the same cycle. A wrong priority order would put them into the queue in a different sequence.

The queue is overfilled by two events. A design that overwrote the oldest entry, or did not keep the overflow flag set, would return the wrong first entries or a clear flag.

Pulses on disabled pins, pushes while the run bit is 0, and a pop on an empty queue must all leave the queue empty and intact. A design that ignored the gating would show pending work or shifted pointers.

// File: rtl/tsu_pkg.sv
package tsu_pkg;
  localparam int TSW = 32;

  typedef enum logic [3:0] {
    EV_SWPUSH = 4'd0,
    EV_ROLL   = 4'd1,
    EV_HALF   = 4'd2,
    EV_PIN    = 4'd3,
    EV_RX     = 4'd4,
    EV_TX     = 4'd5
  } ev_kind_e;

  typedef struct packed {
    logic [31:0]    desc;
    logic [TSW-1:0] ts;
  } ev_rec_t;

  localparam logic [3:0] A_IDENT  = 4'd0;
  localparam logic [3:0] A_CTRL   = 4'd1;
  localparam logic [3:0] A_PUSH   = 4'd2;
  localparam logic [3:0] A_LDVAL  = 4'd3;
  localparam logic [3:0] A_LDGO   = 4'd4;
  localparam logic [3:0] A_STRAW  = 4'd5;
  localparam logic [3:0] A_STMSK  = 4'd6;
  localparam logic [3:0] A_IEN    = 4'd7;
  localparam logic [3:0] A_POP    = 4'd8;
  localparam logic [3:0] A_EVTS   = 4'd9;
  localparam logic [3:0] A_EVDESC = 4'd10;

  function automatic logic [31:0] pack_desc(logic [4:0] port, ev_kind_e kind,
                                            logic [3:0] msg, logic [15:0] seq);
    return {3'b000, port, kind, msg, seq};
  endfunction
endpackage

// File: rtl/tsu_counter.sv
module tsu_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         wrap_full,
  output logic         wrap_half
);
  localparam logic [W-1:0] MID_M1 = {1'b0, {(W-1){1'b1}}};

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (run)  cnt <= cnt + W'(1);
  end

  assign wrap_full = run && !load && (cnt == '1);
  assign wrap_half = run && !load && (cnt == MID_M1);

  assert_incr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load) |=> (cnt == $past(cnt) + W'(1)));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(cnt));
endmodule

// File: rtl/tsu_slot_arb.sv
module tsu_slot_arb #(
  parameter int N = 9
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N-1:0]               fire,
  input  tsu_pkg::ev_rec_t [N-1:0]   rec,
  output logic                       out_valid,
  output tsu_pkg::ev_rec_t           out_rec,
  input  logic                       out_ready,
  output logic                       drop
);
  tsu_pkg::ev_rec_t [N-1:0] held;
  logic [N-1:0] occ;
  logic [N-1:0] grant;

  always_comb begin
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (occ[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
      end
    end
  end

  always_comb begin
    out_rec = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) out_rec = held[i];
    end
  end

  assign out_valid = |occ;
  assign drop = (|(fire & occ & ~grant)) || (out_valid && !out_ready);

  for (genvar g = 0; g < N; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        occ[g]  <= 1'b0;
        held[g] <= '0;
      end else if (fire[g]) begin
        occ[g]  <= 1'b1;
        held[g] <= rec[g];
      end else if (grant[g]) begin
        occ[g]  <= 1'b0;
      end
    end
  end

  assert_grant_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (out_valid == (grant != '0)));
endmodule

// File: rtl/tsu_evfifo.sv
module tsu_evfifo #(
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_valid,
  output logic             push_ready,
  input  tsu_pkg::ev_rec_t push_rec,
  input  logic             pop,
  output tsu_pkg::ev_rec_t head,
  output logic             empty
);
  localparam int AW = $clog2(DEPTH);

  tsu_pkg::ev_rec_t mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   count;
  logic do_push, do_pop;

  assign empty      = (count == '0);
  assign push_ready = (count != (AW+1)'(DEPTH));
  assign do_push    = push_valid && push_ready;
  assign do_pop     = pop && !empty;
  assign head       = mem[rptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= wptr + AW'(1);
      if (do_pop)  rptr <= rptr + AW'(1);
      count <= count + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_rec;
  end

  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (AW+1)'(DEPTH));
  assert_pop_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push_valid) |=> (empty && $stable(rptr)));
endmodule

// File: rtl/tsu_event_capture.sv
module tsu_event_capture #(
  parameter int          N_PINS     = 4,
  parameter int          FIFO_DEPTH = 16,
  parameter logic [15:0] ID_CODE    = 16'h5A17,
  parameter logic [4:0]  ID_RTL     = 5'd3,
  parameter logic [2:0]  ID_MAJ     = 3'd1,
  parameter logic [7:0]  ID_MIN     = 8'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [N_PINS-1:0] hw_pin,
  input  logic              rx_stb,
  input  logic [4:0]        rx_port,
  input  logic [3:0]        rx_msg,
  input  logic [15:0]       rx_seq,
  input  logic              tx_stb,
  input  logic [4:0]        tx_port,
  input  logic [3:0]        tx_msg,
  input  logic [15:0]       tx_seq,
  output logic              irq
);
  import tsu_pkg::*;

  localparam int NSRC = 5 + N_PINS;
  localparam int CW   = 8 + N_PINS;
  localparam logic [31:0] IDENT = {ID_CODE, ID_RTL, ID_MAJ, ID_MIN};

  logic [CW-1:0]   ctrl_q;
  logic [TSW-1:0]  ldval_q, cnt, cnt_nxt;
  logic            ien_q, ovf_q;
  logic [N_PINS-1:0] pin_q, pin_rise;
  logic            run, itest, sw_push, load, pop;
  logic            wrap_full, wrap_half;
  logic [NSRC-1:0] fire;
  ev_rec_t [NSRC-1:0] src_rec;
  logic            arb_valid, arb_ready, drop, fifo_empty, pend_raw;
  ev_rec_t         arb_rec, head;

  assign run     = ctrl_q[0];
  assign itest   = ctrl_q[1];
  assign sw_push = reg_we && reg_addr == A_PUSH && reg_wdata[0];
  assign load    = reg_we && reg_addr == A_LDGO && reg_wdata[0];
  assign pop     = reg_we && reg_addr == A_POP  && reg_wdata[0];
  assign cnt_nxt = cnt + TSW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      ldval_q <= '0;
      ien_q   <= 1'b0;
      ovf_q   <= 1'b0;
      pin_q   <= '0;
    end else begin
      pin_q <= hw_pin;
      if (reg_we && reg_addr == A_CTRL)  ctrl_q  <= reg_wdata[CW-1:0];
      if (reg_we && reg_addr == A_LDVAL) ldval_q <= reg_wdata;
      if (reg_we && reg_addr == A_IEN)   ien_q   <= reg_wdata[0];
      if (drop) ovf_q <= 1'b1;
      else if (reg_we && reg_addr == A_STRAW && reg_wdata[1]) ovf_q <= 1'b0;
    end
  end

  assign pin_rise = hw_pin & ~pin_q & ctrl_q[8 +: N_PINS];
  assign fire = {tx_stb, rx_stb, pin_rise, sw_push, wrap_half, wrap_full}
                & {NSRC{run}};

  always_comb begin
    src_rec[0] = {pack_desc(5'd0, EV_ROLL, 4'd0, 16'd0), cnt_nxt};
    src_rec[1] = {pack_desc(5'd0, EV_HALF, 4'd0, 16'd0), cnt_nxt};
    src_rec[2] = {pack_desc(5'd0, EV_SWPUSH, 4'd0, 16'd0), cnt};
    for (int i = 0; i < N_PINS; i++)
      src_rec[3+i] = {pack_desc(5'(i + 1), EV_PIN, 4'd0, 16'd0), cnt};
    src_rec[3+N_PINS] = {pack_desc(rx_port, EV_RX, rx_msg, rx_seq), cnt};
    src_rec[4+N_PINS] = {pack_desc(tx_port, EV_TX, tx_msg, tx_seq), cnt};
  end

  tsu_counter #(.W(TSW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .load(load), .load_val(ldval_q),
    .cnt(cnt), .wrap_full(wrap_full), .wrap_half(wrap_half)
  );

  tsu_slot_arb #(.N(NSRC)) u_arb (
    .clk(clk), .rst_n(rst_n), .fire(fire), .rec(src_rec),
    .out_valid(arb_valid), .out_rec(arb_rec), .out_ready(arb_ready), .drop(drop)
  );

  tsu_evfifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_valid(arb_valid), .push_ready(arb_ready),
    .push_rec(arb_rec), .pop(pop), .head(head), .empty(fifo_empty)
  );

  assign pend_raw = !fifo_empty || itest;
  assign irq      = pend_raw && ien_q;

  always_comb begin
    case (reg_addr)
      A_IDENT:  reg_rdata = IDENT;
      A_CTRL:   reg_rdata = 32'(ctrl_q);
      A_LDVAL:  reg_rdata = ldval_q;
      A_STRAW:  reg_rdata = {30'd0, ovf_q, pend_raw};
      A_STMSK:  reg_rdata = {31'd0, irq};
      A_IEN:    reg_rdata = {31'd0, ien_q};
      A_EVTS:   reg_rdata = head.ts;
      A_EVDESC: reg_rdata = head.desc;
      default:  reg_rdata = '0;
    endcase
  end

  assert_drop_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ovf_q);
  assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !arb_valid) |=> !arb_valid);
endmodule

// File: tb/tsu_event_capture_bench.sv
module tsu_event_capture_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [3:0] hw_pin = '0;
  logic rx_stb = 0, tx_stb = 0;
  logic [4:0] rx_port = '0, tx_port = '0;
  logic [3:0] rx_msg = '0, tx_msg = '0;
  logic [15:0] rx_seq = '0, tx_seq = '0;
  logic irq;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [63:0] expq[$];
  logic [31:0] m_cnt = 0, m_ld = 0, m_ctrl = 0;
  logic [3:0] m_prev = 0;
  bit m_ovf = 0;

  always #5 clk = ~clk;

  tsu_event_capture u_tsu_event_capture (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_pin(hw_pin),
    .rx_stb(rx_stb), .rx_port(rx_port), .rx_msg(rx_msg), .rx_seq(rx_seq),
    .tx_stb(tx_stb), .tx_port(tx_port), .tx_msg(tx_msg), .tx_seq(tx_seq),
    .irq(irq)
  );

  function automatic logic [31:0] dsc(logic [4:0] p, logic [3:0] k,
                                      logic [3:0] m, logic [15:0] s);
    return {3'b000, p, k, m, s};
  endfunction

  function automatic void exp_ev(logic [31:0] d, logic [31:0] ts);
    if (expq.size() < 16) expq.push_back({d, ts});
    else m_ovf = 1;
  endfunction

  // reference model driven by the port stimulus, ordered per R11
  always @(posedge clk) begin
    if (rst_n) begin
      bit ld;
      ld = reg_we && reg_addr == 4'd4 && reg_wdata[0];
      if (m_ctrl[0]) begin
        if (!ld && m_cnt == 32'hFFFF_FFFF) exp_ev(dsc(0, 1, 0, 0), 32'h0);
        if (!ld && m_cnt == 32'h7FFF_FFFF) exp_ev(dsc(0, 2, 0, 0), 32'h8000_0000);
        if (reg_we && reg_addr == 4'd2 && reg_wdata[0]) exp_ev(dsc(0, 0, 0, 0), m_cnt);
        for (int i = 0; i < 4; i++)
          if (hw_pin[i] && !m_prev[i] && m_ctrl[8+i]) exp_ev(dsc(5'(i+1), 3, 0, 0), m_cnt);
        if (rx_stb) exp_ev(dsc(rx_port, 4, rx_msg, rx_seq), m_cnt);
        if (tx_stb) exp_ev(dsc(tx_port, 5, tx_msg, tx_seq), m_cnt);
      end
      if (ld) m_cnt = m_ld;
      else if (m_ctrl[0]) m_cnt = m_cnt + 1;
      if (reg_we && reg_addr == 4'd3) m_ld = reg_wdata;
      if (reg_we && reg_addr == 4'd1) m_ctrl = reg_wdata;
      if (reg_we && reg_addr == 4'd5 && reg_wdata[1]) m_ovf = 0;
      m_prev = hw_pin;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compares each queued result against the scoreboard
  task automatic drain(string req);
    logic [31:0] ts, de;
    idle(12);
    while (expq.size() > 0) begin
      rd(4'd9, ts);
      rd(4'd10, de);
      chk({req, " R6 R7 desc"}, de, expq[0][63:32]);
      chk({req, " ts"}, ts, expq[0][31:0]);
      void'(expq.pop_front());
      wr(4'd8, 1);
    end
    rd(4'd5, ts);
    chk({req, " R9 empty after drain"}, ts & 1, 0);
  endtask

  task automatic pulse_pin(int i);
    @(negedge clk); hw_pin[i] = 1;
    @(negedge clk); hw_pin[i] = 0;
    idle(2);
  endtask

  initial begin
    logic [31:0] v;
    idle(3);
    rst_n = 1;
    rd(4'd0, v); chk("R12 ident", v, 32'h5A17_1902);
    rd(4'd1, v); chk("R12 ctrl reset", v, 0);
    rd(4'd5, v); chk("R9 raw reset", v, 0);
    chk("R9 irq reset", 32'(irq), 0);

    // R10: disabled means no events
    wr(4'd2, 1);
    wr(4'd1, 32'h0F00);
    pulse_pin(0);
    idle(4);
    rd(4'd5, v); chk("R10 no events while halted", v, 0);

    // R3 software push, R1 load then push
    wr(4'd1, 1);
    wr(4'd2, 1);
    wr(4'd3, 32'd1000);
    wr(4'd4, 1);
    idle(3);
    wr(4'd2, 1);
    idle(3);
    rd(4'd5, v); chk("R9 raw pending", v & 1, 1);
    drain("R1 R3 push");

    // R7 pop on empty has no effect
    wr(4'd8, 1);
    rd(4'd5, v); chk("R7 pop on empty", v, 0);

    // R2 half and full wrap
    wr(4'd3, 32'h7FFF_FFFD);
    wr(4'd4, 1);
    idle(6);
    drain("R2 half");
    wr(4'd3, 32'hFFFF_FFFE);
    wr(4'd4, 1);
    idle(6);
    drain("R2 roll");

    // R4 pins: only pins 0 and 2 enabled
    wr(4'd1, 32'h0501);
    pulse_pin(1);
    idle(3);
    rd(4'd5, v); chk("R4 disabled pin ignored", v, 0);
    pulse_pin(0);
    pulse_pin(2);
    pulse_pin(3);
    drain("R4 pins");

    // R5 and R11: push, rx, tx in one cycle
    @(negedge clk);
    reg_we = 1; reg_addr = 4'd2; reg_wdata = 1;
    rx_stb = 1; rx_port = 5'd17; rx_msg = 4'hA; rx_seq = 16'hBEEF;
    tx_stb = 1; tx_port = 5'd3;  tx_msg = 4'h5; tx_seq = 16'h1234;
    @(negedge clk);
    reg_we = 0; rx_stb = 0; tx_stb = 0;
    idle(5);
    // R9 interrupt masking
    chk("R9 irq masked off", 32'(irq), 0);
    rd(4'd6, v); chk("R9 masked status off", v, 0);
    wr(4'd7, 1);
    rd(4'd6, v); chk("R9 masked status on", v, 1);
    chk("R9 irq on", 32'(irq), 1);
    drain("R5 R11 same cycle");
    chk("R9 irq drops when empty", 32'(irq), 0);
    wr(4'd1, 32'h3);
    rd(4'd5, v); chk("R9 test bit raw", v & 1, 1);
    chk("R9 test bit irq", 32'(irq), 1);
    wr(4'd1, 32'h1);

    // R8 overflow
    for (int k = 0; k < 18; k++) wr(4'd2, 1);
    idle(4);
    rd(4'd5, v); chk("R8 overflow sticky", v, 32'h3);
    drain("R8 full queue");
    rd(4'd5, v); chk("R8 overflow still set", v & 2, 2);
    wr(4'd5, 2);
    rd(4'd5, v); chk("R8 overflow cleared", v, 0);
    chk("R8 model flag", 32'(m_ovf), 0);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule